// File: doc/BRIEF.md
# Indirect Block-Cipher Fetch Controller

This block sits between an exchange register file, a 64-bit main data memory and a 128-bit block-cipher core. A start pulse begins a call. The controller first collects its operands through a small set of pointer and parameter registers. It then fills the core's key store, if the key is not already resident. Next it walks a range of 128-bit blocks in memory. Each block is fetched in two 64-bit beats, passed through the core with optional cipher-block chaining, and written back over its source location. When the last result word has been written, it raises a one-cycle completion pulse.

The cipher rounds are not part of this block. A stub core stands in for them. It has a fixed latency and XORs its input with a fold of the loaded key words. Encryption and decryption therefore use the same function and take the same number of cycles. Key words held in the core survive between calls, so a repeated call with the same key costs no key traffic.

The memory request channel follows valid/ready rules. Once the controller raises `mem_req_valid`, it holds the address, the write flag and the write data unchanged until a cycle in which `mem_req_ready` is high. Back-pressure can last any number of cycles. At most one read is outstanding at a time. The read response carries no ready signal: the controller accepts `mem_rsp_valid` in any cycle after the read handshake.

Top module: `cfc_ctrl`

## Requirements
- R1: After reset, `stop` and `mem_req_valid` are low, and no memory request is issued until a start pulse is seen.
- R2: Operands are read combinationally from exchange registers 0 to 5:
  - 0 is the key pointer, 1 the begin address and 2 the end address (all 64-bit word addresses).
  - 3 is the control word: bit 0 set selects CBC, bit 1 set selects decrypt, and bits 3:2 give the round code (0 for 10 rounds, 1 for 12, 2 or 3 for 14).
  - 4 is the IV bits 63:0 and 5 is the IV bits 127:64.
- R3: A key load reads 2*(rounds+1) consecutive words starting at the key pointer: 22, 26 or 30 words.
- R4: The key load is skipped when no reset has occurred since the last load and both the key pointer and the round code equal those of that load. Otherwise the key is refetched.
- R5: Block layout and write-back:
  - A block occupies word a (bits 63:0) and word a+1 (bits 127:64). Blocks run consecutively from the begin address.
  - The block whose upper word address equals the end address is the last one.
  - Each result is written in place, lower word first. Words outside the range are untouched.
- R6: ECB: result = block XOR K, where K is the XOR over i of the 128-bit pairs {key word 2i+1, key word 2i}. This holds for both directions.
- R7: CBC encrypt: the core input is the block XOR the previous ciphertext block (the IV for the first block), and the result is the core output.
- R8: CBC decrypt: the result is the core output XOR the previous input block (the IV for the first block).
- R9: `stop` is a single-cycle pulse in the cycle after the handshake of the final write.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request address, write flag and write data stay stable.
- R11: A start pulse arriving while a call is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a call (sampled only when idle) |
| stop | output | 1 | One-cycle completion pulse |
| xr_addr | output | 3 | Exchange register index |
| xr_rdata | input | 64 | Exchange register contents, combinational |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 16 | Word address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
The hardest situation to reach from the ports is a key-reuse call whose skip decision is correct. The stimulus repeats a call with an unchanged key pointer and round code, then changes the pointer, then applies a reset with the old pointer. In each case the bench counts read handshakes to tell a skipped load from a refetch. CBC chaining under back-pressure is reached by pausing `mem_req_ready` every third cycle. During that run a spurious start pulse is injected, and the ciphertext from that run is then decrypted in place to recover the plaintext.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_XRD, S_KRQ, S_KRS, S_BRQ, S_BRS, S_GO, S_CORE, S_WRQ
  } cfc_state_t;

  localparam int XR_KEY = 0;
  localparam int XR_BEG = 1;
  localparam int XR_END = 2;
  localparam int XR_CTL = 3;
  localparam int XR_IVL = 4;
  localparam int XR_IVH = 5;
  localparam int XR_N   = 6;

  // key words needed for a round code: 2*(rounds+1), rounds = 10/12/14
  function automatic int unsigned key_words(input logic [1:0] rc);
    int unsigned r;
    r = (rc == 2'd0) ? 10 : (rc == 2'd1) ? 12 : 14;
    return 2 * (r + 1);
  endfunction
endpackage

// File: rtl/cfc_core_stub.sv
module cfc_core_stub #(
  parameter int DW    = 64,
  parameter int MAXKW = 30,
  parameter int LAT   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     key_we,
  input  logic [$clog2(MAXKW)-1:0] key_idx,
  input  logic [DW-1:0]            key_wd,
  input  logic [5:0]               nkw,
  input  logic                     go,
  input  logic [2*DW-1:0]          din,
  output logic                     done,
  output logic [2*DW-1:0]          dout
);
  localparam int CW = $clog2(LAT + 1);

  logic [DW-1:0]   kreg [MAXKW];
  logic [2*DW-1:0] data_q;
  logic [2*DW-1:0] kfold;
  logic [CW-1:0]   cnt;

  // key store is deliberately never cleared
  always_ff @(posedge clk) begin
    if (key_we) kreg[key_idx] <= key_wd;
  end

  always_comb begin
    kfold = '0;
    for (int i = 0; i < MAXKW / 2; i++)
      if (2 * i < int'(nkw)) kfold = kfold ^ {kreg[2*i+1], kreg[2*i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      data_q <= '0;
    end else if (go) begin
      cnt    <= CW'(LAT);
      data_q <= din;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == CW'(1));
  assign dout = data_q ^ kfold;
endmodule

// File: rtl/cfc_chain.sv
module cfc_chain #(
  parameter int BW = 128
) (
  input  logic          cbc,
  input  logic          dec,
  input  logic [BW-1:0] blk,
  input  logic [BW-1:0] prev,
  input  logic [BW-1:0] core_out,
  output logic [BW-1:0] core_in,
  output logic [BW-1:0] result,
  output logic [BW-1:0] next_prev
);
  assign core_in   = (cbc && !dec) ? (blk ^ prev) : blk;
  assign result    = (cbc && dec) ? (core_out ^ prev) : core_out;
  assign next_prev = dec ? blk : core_out;
endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl #(
  parameter int AW         = 16,
  parameter int DW         = 64,
  parameter int MAX_ROUNDS = 14,
  parameter int CORE_LAT   = 4,
  parameter int XW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          stop,
  output logic [XW-1:0] xr_addr,
  input  logic [DW-1:0] xr_rdata,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import cfc_pkg::*;

  localparam int BW    = 2 * DW;
  localparam int MAXKW = 2 * (MAX_ROUNDS + 1);
  localparam int KW    = $clog2(MAXKW);

  cfc_state_t    st;
  logic [XW-1:0] xidx;
  logic [AW-1:0] key_ptr, cur, end_ptr, key_last;
  logic [1:0]    rcode, rc_last;
  logic          cbc, dec, key_ok, half, stop_q;
  logic [KW-1:0] kcnt;
  logic [BW-1:0] blk_q, res_q, prev_q;
  logic [5:0]    nkw;

  logic [BW-1:0] core_in, core_out, result, next_prev;
  logic          core_done, core_go, key_we, hs;

  assign nkw     = 6'(key_words(rcode));
  assign hs      = mem_req_valid && mem_req_ready;
  assign core_go = (st == S_GO);
  assign key_we  = (st == S_KRS) && mem_rsp_valid;

  assign xr_addr       = xidx;
  assign mem_req_valid = (st == S_KRQ) || (st == S_BRQ) || (st == S_WRQ);
  assign mem_req_we    = (st == S_WRQ);
  assign mem_req_addr  = (st == S_KRQ) ? (key_ptr + AW'(kcnt)) : (cur + AW'(half));
  assign mem_req_wdata = half ? res_q[BW-1:DW] : res_q[DW-1:0];
  assign stop          = stop_q;

  cfc_core_stub #(.DW(DW), .MAXKW(MAXKW), .LAT(CORE_LAT)) u_core (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_idx(kcnt),
    .key_wd(mem_rsp_data), .nkw(nkw), .go(core_go), .din(core_in),
    .done(core_done), .dout(core_out)
  );

  cfc_chain #(.BW(BW)) u_chain (
    .cbc(cbc), .dec(dec), .blk(blk_q), .prev(prev_q), .core_out(core_out),
    .core_in(core_in), .result(result), .next_prev(next_prev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      xidx     <= '0;
      key_ptr  <= '0;
      cur      <= '0;
      end_ptr  <= '0;
      key_last <= '0;
      rcode    <= '0;
      rc_last  <= '0;
      cbc      <= 1'b0;
      dec      <= 1'b0;
      key_ok   <= 1'b0;
      half     <= 1'b0;
      stop_q   <= 1'b0;
      kcnt     <= '0;
      blk_q    <= '0;
      res_q    <= '0;
      prev_q   <= '0;
    end else begin
      stop_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          xidx <= '0;
          st   <= S_XRD;
        end
        S_XRD: begin
          xidx <= xidx + 1'b1;
          case (int'(xidx))
            XR_KEY: key_ptr <= xr_rdata[AW-1:0];
            XR_BEG: cur     <= xr_rdata[AW-1:0];
            XR_END: end_ptr <= xr_rdata[AW-1:0];
            XR_CTL: begin
              cbc   <= xr_rdata[0];
              dec   <= xr_rdata[1];
              rcode <= xr_rdata[3:2];
            end
            XR_IVL: prev_q[DW-1:0] <= xr_rdata;
            default: begin
              prev_q[BW-1:DW] <= xr_rdata;
              half <= 1'b0;
              kcnt <= '0;
              if (key_ok && key_last == key_ptr && rc_last == rcode) st <= S_BRQ;
              else st <= S_KRQ;
            end
          endcase
        end
        S_KRQ: if (hs) st <= S_KRS;
        S_KRS: if (mem_rsp_valid) begin
          if (6'(kcnt) == nkw - 6'd1) begin
            key_ok   <= 1'b1;
            key_last <= key_ptr;
            rc_last  <= rcode;
            st       <= S_BRQ;
          end else begin
            kcnt <= kcnt + 1'b1;
            st   <= S_KRQ;
          end
        end
        S_BRQ: if (hs) st <= S_BRS;
        S_BRS: if (mem_rsp_valid) begin
          if (!half) begin
            blk_q[DW-1:0] <= mem_rsp_data;
            half <= 1'b1;
            st   <= S_BRQ;
          end else begin
            blk_q[BW-1:DW] <= mem_rsp_data;
            half <= 1'b0;
            st   <= S_GO;
          end
        end
        S_GO: st <= S_CORE;
        S_CORE: if (core_done) begin
          res_q  <= result;
          prev_q <= next_prev;
          st     <= S_WRQ;
        end
        S_WRQ: if (hs) begin
          if (!half) begin
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            if (cur + AW'(1) == end_ptr) begin
              stop_q <= 1'b1;
              st     <= S_IDLE;
            end else begin
              cur <= cur + AW'(2);
              st  <= S_BRQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfc_ctrl_chk.sv
module cfc_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata
);
  logic busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else if (stop) busy <= start;
    else busy <= busy | start;
  end

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r9_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !stop);

  a_r9_stop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> $past(mem_req_valid && mem_req_ready && mem_req_we));

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
endmodule

bind cfc_ctrl cfc_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/cfc_ctrl_test.sv
module cfc_ctrl_test;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stop;
  logic [2:0]  xr_addr;
  logic [63:0] xr_rdata;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [15:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  logic [63:0] xregs [8];
  logic [63:0] mem [256];
  int errors = 0, checks = 0, stop_cnt = 0, rd_cnt = 0, cyc = 0;
  logic stall = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  assign xr_rdata = xregs[xr_addr];

  cfc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .xr_addr(xr_addr), .xr_rdata(xr_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // memory responder
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= stall ? ((cyc % 3) != 0) : 1'b1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_we;
    mem_rsp_data  <= mem[mem_req_addr[7:0]];
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata;
      else rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) if (stop) stop_cnt = stop_cnt + 1;

  initial begin
    while (cyc < 150000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [63:0] kw(input int a);
    return (64'h0123_4567_89AB_CDEF * 64'(a + 1)) ^ 64'(a);
  endfunction

  function automatic logic [127:0] kfold(input int kp, input int rc);
    logic [127:0] k = '0;
    int n = 2 * (10 + 2 * rc + 1);
    for (int i = 0; i < n / 2; i++) k ^= {kw(kp + 2*i + 1), kw(kp + 2*i)};
    return k;
  endfunction

  function automatic logic [127:0] ptxt(input int i, input int s);
    return {32'hFEED0000 + 32'(s), 32'(i * 7 + 1), 32'hC0FFEE00 ^ 32'(i), 32'(s * 13 + i)};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_key(input int kp, input int rc);
    for (int i = 0; i < 2 * (10 + 2 * rc + 1); i++) mem[kp + i] <= kw(kp + i);
    @(negedge clk);
  endtask

  task automatic setup(input int kp, input int b, input int e, input int ctl,
                       input logic [127:0] iv);
    xregs[0] = 64'(kp); xregs[1] = 64'(b); xregs[2] = 64'(e);
    xregs[3] = 64'(ctl); xregs[4] = iv[63:0]; xregs[5] = iv[127:64];
  endtask

  task automatic run(input bit extra_start);
    int t = 0;
    int s0 = stop_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (stop_cnt == s0 && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [127:0] rdblk(input int a);
    return {mem[a + 1], mem[a]};
  endfunction

  task automatic t_reset;
    chk("R1 stop low", 128'(stop), 128'(0));
    chk("R1 no request", 128'(mem_req_valid), 128'(0));
    repeat (5) @(negedge clk);
    chk("R1 still quiet", 128'(mem_req_valid), 128'(0));
  endtask

  task automatic t_ecb_enc;
    logic [127:0] k = kfold(16, 0);
    int r0;
    load_key(16, 0);
    for (int i = 0; i < 3; i++) begin
      mem[128 + 2*i] <= ptxt(i, 1)[63:0];
      mem[129 + 2*i] <= ptxt(i, 1)[127:64];
    end
    mem[134] <= 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    setup(16, 128, 133, 0, '0);
    r0 = rd_cnt; stop_cnt = 0;
    run(0);
    chk("R3 key words 22 plus 6 data", 128'(rd_cnt - r0), 128'(28));
    for (int i = 0; i < 3; i++) chk("R6 R2 ECB encrypt", rdblk(128 + 2*i), ptxt(i, 1) ^ k);
    chk("R5 word past end untouched", 128'(mem[134]), 128'(64'hDEAD_BEEF_0000_0001));
    chk("R9 one stop pulse", 128'(stop_cnt), 128'(1));
  endtask

  task automatic t_reuse_dec;
    logic [127:0] k = kfold(16, 0);
    int r0;
    for (int i = 0; i < 2; i++) begin
      mem[144 + 2*i] <= ptxt(i, 2)[63:0];
      mem[145 + 2*i] <= ptxt(i, 2)[127:64];
    end
    @(negedge clk);
    setup(16, 144, 147, 2, '0);
    r0 = rd_cnt;
    run(0);
    chk("R4 key skipped on reuse", 128'(rd_cnt - r0), 128'(4));
    for (int i = 0; i < 2; i++) chk("R6 ECB decrypt", rdblk(144 + 2*i), ptxt(i, 2) ^ k);
  endtask

  task automatic t_cbc_enc_stall;
    logic [127:0] k = kfold(16, 0);
    logic [127:0] iv = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    logic [127:0] c = iv;
    for (int i = 0; i < 4; i++) begin
      mem[160 + 2*i] <= ptxt(i, 3)[63:0];
      mem[161 + 2*i] <= ptxt(i, 3)[127:64];
    end
    @(negedge clk);
    setup(16, 160, 167, 1, iv);
    stall = 1'b1; stop_cnt = 0;
    run(1);
    stall = 1'b0;
    for (int i = 0; i < 4; i++) begin
      c = (ptxt(i, 3) ^ c) ^ k;
      chk("R7 R10 CBC encrypt under stall", rdblk(160 + 2*i), c);
    end
    chk("R11 extra start ignored", 128'(stop_cnt), 128'(1));
  endtask

  task automatic t_cbc_dec;
    logic [127:0] iv = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
    setup(16, 160, 167, 3, iv);
    run(0);
    for (int i = 0; i < 4; i++) chk("R8 CBC decrypt recovers", rdblk(160 + 2*i), ptxt(i, 3));
  endtask

  task automatic t_new_key;
    logic [127:0] k = kfold(64, 2);
    int r0;
    load_key(64, 2);
    mem[192] <= ptxt(9, 4)[63:0]; mem[193] <= ptxt(9, 4)[127:64];
    @(negedge clk);
    setup(64, 192, 193, 8, '0);
    r0 = rd_cnt;
    run(0);
    chk("R3 R4 new key 30 words plus 2", 128'(rd_cnt - r0), 128'(32));
    chk("R5 single block", rdblk(192), ptxt(9, 4) ^ k);
  endtask

  task automatic t_reset_refetch;
    int r0;
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    setup(64, 192, 193, 8, '0);
    r0 = rd_cnt;
    run(0);
    chk("R4 refetch after reset", 128'(rd_cnt - r0), 128'(32));
    chk("R6 restored block", rdblk(192), ptxt(9, 4));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 8; i++) xregs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ecb_enc();
    t_reuse_dec();
    t_cbc_enc_stall();
    t_cbc_dec();
    t_new_key();
    t_reset_refetch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule